// File: doc/BRIEF.md
# MII Management Frame Handler

This block sits behind a host register interface. It carries PHY register accesses, written by the host as a single 32-bit management frame word, to an internal model of a PHY register file. The host writes the frame word. The block decodes the start code, the opcode, the PHY address and the register address. It then performs the access against a 32-entry by 16-bit register model and sets the turnaround-complete bit. From the next cycle on, the frame register reads back the finished word. For a read, that word holds the register contents in the data field.

The PHY model behaves like a simple internal transceiver:
- A control write with the reset bit set is stored with that bit cleared and autonegotiation enabled.
- A control write with the restart bit set marks negotiation complete. When the link is up, it also reports link status and the partner's 100BASE-TX full-duplex ability.
- A link-up input keeps the link-status and partner-ability bits current.

A separate configuration register is writable except for two PHY-present bits, which host writes never change.

Top module: `mii_mgmt_frame`

## Requirements
- R1: One cycle after a frame write, the frame register holds bits 31:17 exactly as written and has bit 16 (turnaround low bit) set, whatever the frame contains. Frame fields are: start 31:30, opcode 29:28, PHY address 27:23, register address 22:18, turnaround 17:16, data 15:0.
- R2: A frame whose start field is not 01 performs no register access, and its data field reads back unchanged.
- R3: A frame whose PHY address is not 1 performs no register access, and its data field reads back unchanged.
- R4: Opcode 01 stores the data field into the addressed PHY register. Opcode 10 replaces the data field with that register's contents. Opcodes 00 and 11 perform no access.
- R5: Configuration register bits 9:8 are read-only and keep their value across host writes. All other bits take the written value. The reset value is 0x00000100.
- R6: A write to PHY register 0 (control) with bit 15 set stores the value with bit 15 cleared and bit 12 (autonegotiation enable) set.
- R7: A write to the control register with bit 9 (restart) set stores bit 9 cleared and sets status (register 1) bit 5. If the link input is high, it also sets status bit 2 and partner-ability (register 5) bit 8.
- R8: After reset, control reads 0x0000, advertisement (register 4) reads 0x0100, and registers 2 and 3 read the identifier parameters. Status reads 0x4008 with bit 2 added, and partner ability reads 0x0100, once a high link input has been seen.
- R9: A falling link input clears status bit 2 and partner-ability bit 8. A rising link input sets them both.
- R10: Other PHY registers, such as 7 and 31, are plain 16-bit storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link state seen by the PHY model |
| frm_wr | input | 1 | Write strobe for the frame register |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| wdata | input | 32 | Host write data, shared by both registers |
| frm_rdata | output | 32 | Frame register contents |
| cfg_rdata | output | 32 | Configuration register contents |

## Verification
The hardest case to reach is a negotiation restart issued while the link is down. It only differs from the link-up case after the status and partner bits have first been knocked down by a falling link edge. The bench therefore drops the link input and confirms that both bits cleared. It then issues the restart and expects only the negotiation-complete bit to appear. Finally it raises the link input again and expects the link bits to return.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

  localparam int REG_AW    = 5;
  localparam int DATA_W    = 16;
  localparam int FRAME_W   = 32;
  localparam int NUM_REGS  = 1 << REG_AW;

  typedef struct packed {
    logic [1:0]        st;
    logic [1:0]        op;
    logic [4:0]        pa;
    logic [REG_AW-1:0] ra;
    logic [1:0]        ta;
    logic [DATA_W-1:0] data;
  } frame_t;

  localparam logic [1:0] ST_OK  = 2'b01;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;

  localparam logic [REG_AW-1:0] REG_CTL  = 5'd0;
  localparam logic [REG_AW-1:0] REG_STAT = 5'd1;
  localparam logic [REG_AW-1:0] REG_ID1  = 5'd2;
  localparam logic [REG_AW-1:0] REG_ID2  = 5'd3;
  localparam logic [REG_AW-1:0] REG_ADV  = 5'd4;
  localparam logic [REG_AW-1:0] REG_LPA  = 5'd5;

  localparam int CTL_RST_B     = 15;
  localparam int CTL_ANEN_B    = 12;
  localparam int CTL_RESTART_B = 9;
  localparam int STAT_FD100_B  = 14;
  localparam int STAT_ANDONE_B = 5;
  localparam int STAT_ANABL_B  = 3;
  localparam int STAT_LINK_B   = 2;
  localparam int ABIL_FD100_B  = 8;

  localparam logic [DATA_W-1:0] STAT_BASE = DATA_W'((1 << STAT_FD100_B) | (1 << STAT_ANABL_B));
  localparam logic [DATA_W-1:0] ADV_BASE  = DATA_W'(1 << ABIL_FD100_B);

  // Value actually stored when the host writes the control register.
  function automatic logic [DATA_W-1:0] ctl_fix(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = d;
    if (d[CTL_RST_B]) begin
      r[CTL_RST_B]  = 1'b0;
      r[CTL_ANEN_B] = 1'b1;
    end
    r[CTL_RESTART_B] = 1'b0;
    return r;
  endfunction

  // Completed frame word: header kept, completion bit set, data replaced on reads.
  function automatic logic [FRAME_W-1:0] frame_done(input logic [FRAME_W-1:0] w,
                                                     input logic [DATA_W-1:0]  rd,
                                                     input logic               is_rd);
    return {w[FRAME_W-1:DATA_W+1], 1'b1, (is_rd ? rd : w[DATA_W-1:0])};
  endfunction

endpackage

// File: rtl/mgmt_frame_decode.sv
module mgmt_frame_decode
  import mii_mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic              valid,
  input  logic [1:0]        st,
  input  logic [1:0]        op,
  input  logic [4:0]        pa,
  output logic              do_wr,
  output logic              do_rd,
  output logic              reject
);
  logic hdr_ok;

  always_comb begin
    hdr_ok = valid && (st == ST_OK) && (pa == PHY_ADDR);
    do_wr  = hdr_ok && (op == OP_WR);
    do_rd  = hdr_ok && (op == OP_RD);
    reject = valid && !(do_wr || do_rd);
  end
endmodule

// File: rtl/phy_reg_model.sv
module phy_reg_model
  import mii_mgmt_pkg::*;
#(
  parameter int                AW     = REG_AW,
  parameter int                DW     = DATA_W,
  parameter logic [DW-1:0]     ID_HI  = 16'h0A5C,
  parameter logic [DW-1:0]     ID_LO  = 16'h3E10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_up,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ctl_o,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] lpa_o,
  output logic          link_rise_o,
  output logic          link_fall_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] regs_q   [DEPTH];
  logic [DW-1:0] regs_nxt [DEPTH];
  logic          link_q;
  logic          ctl_hit;
  logic          restart_hit;

  function automatic logic [DW-1:0] rst_val(input int idx);
    if (idx == int'(REG_STAT))     return STAT_BASE;
    else if (idx == int'(REG_ADV)) return ADV_BASE;
    else if (idx == int'(REG_ID1)) return ID_HI;
    else if (idx == int'(REG_ID2)) return ID_LO;
    else                           return '0;
  endfunction

  assign link_rise_o = link_up && !link_q;
  assign link_fall_o = !link_up && link_q;
  assign ctl_hit     = wr_en && (addr == REG_CTL);
  assign restart_hit = ctl_hit && wr_data[CTL_RESTART_B];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) regs_nxt[i] = regs_q[i];
    if (wr_en) regs_nxt[addr] = ctl_hit ? ctl_fix(wr_data) : wr_data;
    if (restart_hit) begin
      regs_nxt[REG_STAT][STAT_ANDONE_B] = 1'b1;
      if (link_up) begin
        regs_nxt[REG_STAT][STAT_LINK_B] = 1'b1;
        regs_nxt[REG_LPA][ABIL_FD100_B] = 1'b1;
      end
    end
    if (link_rise_o) begin
      regs_nxt[REG_STAT][STAT_LINK_B] = 1'b1;
      regs_nxt[REG_LPA][ABIL_FD100_B] = 1'b1;
    end
    if (link_fall_o) begin
      regs_nxt[REG_STAT][STAT_LINK_B] = 1'b0;
      regs_nxt[REG_LPA][ABIL_FD100_B] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) regs_q[i] <= rst_val(i);
    end else begin
      link_q <= link_up;
      for (int i = 0; i < DEPTH; i++) regs_q[i] <= regs_nxt[i];
    end
  end

  assign rd_data  = regs_q[addr];
  assign ctl_o    = regs_q[REG_CTL];
  assign status_o = regs_q[REG_STAT];
  assign lpa_o    = regs_q[REG_LPA];
endmodule

// File: rtl/mgmt_cfg_reg.sv
module mgmt_cfg_reg #(
  parameter int            W        = 32,
  parameter logic [W-1:0]  RO_MASK  = 32'h0000_0300,
  parameter logic [W-1:0]  RST_VAL  = 32'h0000_0100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= (wr_data & ~RO_MASK) | (q & RO_MASK);
  end
endmodule

// File: rtl/mii_mgmt_frame.sv
module mii_mgmt_frame
  import mii_mgmt_pkg::*;
#(
  parameter logic [4:0]        PHY_ADDR = 5'd1,
  parameter logic [DATA_W-1:0] ID_HI    = 16'h0A5C,
  parameter logic [DATA_W-1:0] ID_LO    = 16'h3E10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_up,
  input  logic               frm_wr,
  input  logic               cfg_wr,
  input  logic [FRAME_W-1:0] wdata,
  output logic [FRAME_W-1:0] frm_rdata,
  output logic [FRAME_W-1:0] cfg_rdata
);
  frame_t             fw;
  logic               do_wr, do_rd, reject;
  logic [DATA_W-1:0]  rd_data, ctl_w, status_w, lpa_w;
  logic               link_rise, link_fall;
  logic [FRAME_W-1:0] frame_q;

  assign fw = frame_t'(wdata);

  mgmt_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .valid (frm_wr),
    .st    (fw.st),
    .op    (fw.op),
    .pa    (fw.pa),
    .do_wr (do_wr),
    .do_rd (do_rd),
    .reject(reject)
  );

  phy_reg_model #(.AW(REG_AW), .DW(DATA_W), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_phy (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_up    (link_up),
    .wr_en      (do_wr),
    .addr       (fw.ra),
    .wr_data    (fw.data),
    .rd_data    (rd_data),
    .ctl_o      (ctl_w),
    .status_o   (status_w),
    .lpa_o      (lpa_w),
    .link_rise_o(link_rise),
    .link_fall_o(link_fall)
  );

  mgmt_cfg_reg #(.W(FRAME_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr),
    .wr_data(wdata),
    .q      (cfg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frame_q <= '0;
    else if (frm_wr) frame_q <= frame_done(wdata, rd_data, do_rd);
  end

  assign frm_rdata = frame_q;
endmodule

// File: rtl/mii_mgmt_frame_chk.sv
module mii_mgmt_frame_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        link_up,
  input logic        frm_wr,
  input logic        cfg_wr,
  input logic [31:0] wdata,
  input logic [31:0] frm_rdata,
  input logic [31:0] cfg_rdata,
  input logic        do_wr,
  input logic        do_rd,
  input logic        reject,
  input logic [4:0]  reg_addr,
  input logic [15:0] rd_data,
  input logic [15:0] ctl,
  input logic [15:0] status,
  input logic [15:0] lpa,
  input logic        link_rise,
  input logic        link_fall
);
  // R1
  frame_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_wr |=> frm_rdata[16] && frm_rdata[31:17] == $past(wdata[31:17]));

  // R2
  reject_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> frm_rdata[15:0] == $past(wdata[15:0]));

  // R3
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_wr, do_rd, reject}));

  // R4
  read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_rd |=> frm_rdata[15:0] == $past(rd_data));

  // R5
  cfg_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata[9:8] == $past(cfg_rdata[9:8]));

  // R6
  ctl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && reg_addr == 5'd0 && wdata[15]) |=> !ctl[15] && ctl[12]);

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && reg_addr == 5'd0 && wdata[9] && link_up) |=> !ctl[9] && status[5] && status[2] && lpa[8]);

  // R9
  link_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_fall |=> !status[2] && !lpa[8]);

  // R9
  link_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_rise |=> status[2] && lpa[8]);
endmodule

bind mii_mgmt_frame mii_mgmt_frame_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .link_up  (link_up),
  .frm_wr   (frm_wr),
  .cfg_wr   (cfg_wr),
  .wdata    (wdata),
  .frm_rdata(frm_rdata),
  .cfg_rdata(cfg_rdata),
  .do_wr    (do_wr),
  .do_rd    (do_rd),
  .reject   (reject),
  .reg_addr (fw.ra),
  .rd_data  (rd_data),
  .ctl      (ctl_w),
  .status   (status_w),
  .lpa      (lpa_w),
  .link_rise(link_rise),
  .link_fall(link_fall)
);

// File: tb/test_mii_mgmt_frame.sv
module test_mii_mgmt_frame;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b1;
  logic        frm_wr = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] frm_rdata, cfg_rdata;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  mii_mgmt_frame i_mii_mgmt_frame (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .frm_wr(frm_wr),
    .cfg_wr(cfg_wr), .wdata(wdata), .frm_rdata(frm_rdata), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] pa, input logic [4:0] ra,
                                     input logic [15:0] d);
    return {st, op, pa, ra, 2'b00, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [31:0] w);
    @(negedge clk); frm_wr = 1'b1; wdata = w;
    @(negedge clk); frm_wr = 1'b0;
  endtask

  task automatic phy_wr(input logic [4:0] ra, input logic [15:0] d);
    frame(mk(2'b01, 2'b01, 5'd1, ra, d));
  endtask

  task automatic phy_rd_chk(input string req, input logic [4:0] ra, input logic [15:0] exp);
    logic [31:0] w;
    w = mk(2'b01, 2'b10, 5'd1, ra, 16'h0);
    frame(w);
    chk(req, frm_rdata, {w[31:17], 1'b1, exp});
  endtask

  task automatic t_reset;
    chk("R1 reset frame", frm_rdata, 32'h0);
    chk("R5 reset cfg", cfg_rdata, 32'h0000_0100);
    phy_rd_chk("R8 ctl", 5'd0, 16'h0000);
    phy_rd_chk("R8 status", 5'd1, 16'h400C);
    phy_rd_chk("R8 id hi", 5'd2, 16'h0A5C);
    phy_rd_chk("R8 id lo", 5'd3, 16'h3E10);
    phy_rd_chk("R8 adv", 5'd4, 16'h0100);
    phy_rd_chk("R8 lpa", 5'd5, 16'h0100);
  endtask

  task automatic t_storage;
    logic [31:0] w;
    w = mk(2'b01, 2'b01, 5'd1, 5'd7, 16'hBEEF);
    frame(w);
    chk("R1 write completes", frm_rdata, w | 32'h0001_0000);
    phy_rd_chk("R4 R10 reg7", 5'd7, 16'hBEEF);
    phy_wr(5'd31, 16'h1357);
    phy_rd_chk("R10 reg31", 5'd31, 16'h1357);
  endtask

  task automatic t_reject;
    logic [31:0] w;
    w = mk(2'b01, 2'b00, 5'd1, 5'd7, 16'h1111);
    frame(w); chk("R4 op00 frame", frm_rdata, w | 32'h0001_0000);
    frame(mk(2'b01, 2'b11, 5'd1, 5'd7, 16'h2222));
    phy_rd_chk("R4 op00/11 no access", 5'd7, 16'hBEEF);
    w = mk(2'b00, 2'b01, 5'd1, 5'd7, 16'h3333);
    frame(w); chk("R2 bad start frame", frm_rdata, w | 32'h0001_0000);
    frame(mk(2'b11, 2'b01, 5'd1, 5'd7, 16'h4444));
    phy_rd_chk("R2 no access", 5'd7, 16'hBEEF);
    w = mk(2'b01, 2'b01, 5'd0, 5'd7, 16'h5555);
    frame(w); chk("R3 addr0 frame", frm_rdata, w | 32'h0001_0000);
    frame(mk(2'b01, 2'b01, 5'd2, 5'd7, 16'h6666));
    phy_rd_chk("R3 no access", 5'd7, 16'hBEEF);
    w = mk(2'b01, 2'b10, 5'd0, 5'd7, 16'h7777);
    frame(w); chk("R3 read addr0 echo", frm_rdata, w | 32'h0001_0000);
  endtask

  task automatic t_cfg;
    @(negedge clk); cfg_wr = 1'b1; wdata = 32'hFFFF_FCFF;
    @(negedge clk); cfg_wr = 1'b0;
    chk("R5 cfg ro kept", cfg_rdata, 32'hFFFF_FDFF);
    @(negedge clk); cfg_wr = 1'b1; wdata = 32'h0000_0200;
    @(negedge clk); cfg_wr = 1'b0;
    chk("R5 cfg ro ignore", cfg_rdata, 32'h0000_0100);
  endtask

  task automatic t_ctl;
    phy_wr(5'd0, 16'h8000);
    phy_rd_chk("R6 reset bit", 5'd0, 16'h1000);
    phy_wr(5'd0, 16'h0200);
    phy_rd_chk("R7 restart cleared", 5'd0, 16'h0000);
    phy_rd_chk("R7 status link up", 5'd1, 16'h402C);
  endtask

  task automatic t_link;
    @(negedge clk); link_up = 1'b0;
    @(negedge clk);
    phy_rd_chk("R9 fall status", 5'd1, 16'h4028);
    phy_rd_chk("R9 fall lpa", 5'd5, 16'h0000);
    phy_wr(5'd0, 16'h8200);
    phy_rd_chk("R6 R7 ctl both", 5'd0, 16'h1000);
    phy_rd_chk("R7 restart link down", 5'd1, 16'h4028);
    phy_rd_chk("R7 lpa link down", 5'd5, 16'h0000);
    @(negedge clk); link_up = 1'b1;
    @(negedge clk);
    phy_rd_chk("R9 rise status", 5'd1, 16'h402C);
    phy_rd_chk("R9 rise lpa", 5'd5, 16'h0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_storage;
    t_reject;
    t_cfg;
    t_ctl;
    t_link;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule